// File: doc/BRIEF.md
# Watchdog Timer with Two-Write Refresh Key

A supervisory timer clocked from the CPU clock. A prescaler divides the clock by one of two ratios, chosen by `div_sel_i`, and each prescaler tick decrements a down-counter. When the counter passes below zero it reloads to its full value. At the same time it emits a one-cycle pulse, which goes either to an interrupt output or to a system-reset request output, depending on `act_sel_i`.

Software keeps the timer alive through a byte-wide write port. A refresh takes a key of two writes to the refresh address: 00h first, then FFh. Any write to the start address starts a timer that was configured to wait. A strap-like input, `auto_stop_cfg_i`, chooses between two behaviours after reset: start counting at once, or stay frozen until the first start write. The stop-mode and wait-mode inputs freeze the count, and counting continues from the held value when they drop. The live count is readable on `count_o`.

Top module: `wdt_top`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `count_o` equals all ones (2^CNT_W-1). Both `irq_o` and `rst_req_o` are low, and the prescaler is cleared.
- R2: While enabled, `count_o` falls by exactly one every n clock cycles. n is LO_DIV when `div_sel_i`=0 and HI_DIV when `div_sel_i`=1 (defaults 16 and 128). Otherwise it changes only by reloading to all ones.
- R3: Consecutive underflow pulses of a free-running timer are n·2^CNT_W cycles apart. In the cycle a pulse is visible, `count_o` is all ones.
- R4: A write of 00h to the refresh address (`wr_addr_i`=0) followed by a write of FFh to that address reloads `count_o` to all ones on the FFh write's clock edge.
- R5: A refresh-address write of any value other than FFh after 00h cancels the key. An FFh write with no armed 00h leaves the count unchanged.
- R6: With `auto_stop_cfg_i`=1 the count stays at all ones after reset until any write to the start address (`wr_addr_i`=1). It then decrements as in R2.
- R7: With `auto_stop_cfg_i`=0 the timer counts from the first clock edge after reset.
- R8: While `stop_mode_i` or `wait_mode_i` is high, the count and the prescaler hold, and counting resumes from the held values afterwards.
- R9: Underflow yields a one-cycle pulse on `irq_o` when `act_sel_i`=0 and on `rst_req_o` when `act_sel_i`=1. The two are never high together.
- R10: A refresh key that completes on the same edge as an underflow reloads the counter and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock, count source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| auto_stop_cfg_i | input | 1 | 1: wait for start write after reset; 0: run at once |
| div_sel_i | input | 1 | Prescaler ratio select (0: LO_DIV, 1: HI_DIV) |
| act_sel_i | input | 1 | Underflow action (0: interrupt, 1: reset request) |
| stop_mode_i | input | 1 | Stop mode, freezes counting |
| wait_mode_i | input | 1 | Wait mode, freezes counting |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 1 | 0: refresh register, 1: start register |
| wr_data_i | input | 8 | Write data |
| count_o | output | CNT_W | Current counter value |
| irq_o | output | 1 | Watchdog interrupt pulse |
| rst_req_o | output | 1 | Watchdog reset request pulse |

## Verification
A refresh key can complete on the very edge at which the counter would pass below zero, so reload and underflow compete in one cycle. The bench provokes this with the slower divisor. It waits until `count_o` first reads zero, which puts the prescaler at phase zero. It then times the 00h write to the next-to-last prescaler edge and the FFh write to the last. The expected result is a full count and no pulse on either output, in that cycle or the next. Pseudo-random sweeps over every configuration compare each cycle against an arithmetic model, which also lands such collisions by chance.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic       ADDR_REFRESH = 1'b0;
  localparam logic       ADDR_START   = 1'b1;
  localparam logic [7:0] KEY_ARM      = 8'h00;
  localparam logic [7:0] KEY_FIRE     = 8'hFF;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int LO_DIV = 16,
  parameter int HI_DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic div_sel_i,
  output logic tick_o
);
  localparam int MAX_DIV = (HI_DIV > LO_DIV) ? HI_DIV : LO_DIV;
  localparam int PW      = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam logic [PW-1:0] LO_TERM = PW'(LO_DIV - 1);
  localparam logic [PW-1:0] HI_TERM = PW'(HI_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] term;

  assign term   = div_sel_i ? HI_TERM : LO_TERM;
  // >= so a ratio change mid-count cannot skip the wrap
  assign tick_o = en_i && (pre_q >= term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else if (en_i)    pre_q <= pre_q + PW'(1);
  end
endmodule

// File: rtl/wdt_refresh.sv
module wdt_refresh
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic       reload_o
);
  logic armed_q;

  assign reload_o = wr_en_i && armed_q && (wr_data_i == KEY_FIRE);

  // every refresh-address write re-decides the key state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (wr_en_i) armed_q <= (wr_data_i == KEY_ARM);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             underflow_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= FULL;
      uf_q  <= 1'b0;
    end else begin
      uf_q <= 1'b0;
      if (reload_i) begin
        cnt_q <= FULL;           // refresh beats a coincident underflow
      end else if (tick_i) begin
        if (cnt_q == '0) begin
          cnt_q <= FULL;
          uf_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign count_o     = cnt_q;
  assign underflow_o = uf_q;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int LO_DIV = 16,
  parameter int HI_DIV = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_stop_cfg_i,
  input  logic             div_sel_i,
  input  logic             act_sel_i,
  input  logic             stop_mode_i,
  input  logic             wait_mode_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [7:0]       wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic started_q;
  logic count_en;
  logic tick;
  logic reload;
  logic uf;
  logic start_wr;
  logic refresh_wr;

  assign start_wr   = wr_en_i && (wr_addr_i == ADDR_START);
  assign refresh_wr = wr_en_i && (wr_addr_i == ADDR_REFRESH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       started_q <= 1'b0;
    else if (start_wr) started_q <= 1'b1;
  end

  assign count_en = (started_q || !auto_stop_cfg_i) && !stop_mode_i && !wait_mode_i;

  wdt_prescaler #(.LO_DIV(LO_DIV), .HI_DIV(HI_DIV)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (count_en),
    .div_sel_i (div_sel_i),
    .tick_o    (tick)
  );

  wdt_refresh u_ref (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (refresh_wr),
    .wr_data_i (wr_data_i),
    .reload_o  (reload)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .reload_i    (reload),
    .count_o     (count_o),
    .underflow_o (uf)
  );

  assign irq_o     = uf && !act_sel_i;
  assign rst_req_o = uf &&  act_sel_i;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_mode_i,
  input logic             wait_mode_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             rst_req_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && rst_req_o));

  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || rst_req_o) |=> !(irq_o || rst_req_o));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |->
      ((count_o == $past(count_o) - CNT_W'(1)) || (count_o == FULL)));

  p_full_at_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || rst_req_o) |-> (count_o == FULL));

  p_from_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || rst_req_o) |-> ($past(count_o) == '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stop_mode_i || wait_mode_i) && !wr_en_i) |=> $stable(count_o));
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stop_mode_i (stop_mode_i),
  .wait_mode_i (wait_mode_i),
  .wr_en_i     (wr_en_i),
  .count_o     (count_o),
  .irq_o       (irq_o),
  .rst_req_o   (rst_req_o)
);

// File: tb/tb_wdt_top.sv
`timescale 1ns/1ps
module tb_wdt_top;
  localparam int CW = 4;
  localparam int LO = 2;
  localparam int HI = 4;
  localparam logic [CW-1:0] FULL = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_cfg = 1'b0, div_sel = 1'b0, act_sel = 1'b0;
  logic stop_m = 1'b0, wait_m = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [CW-1:0] count;
  logic irq, rreq;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  wdt_top #(.CNT_W(CW), .LO_DIV(LO), .HI_DIV(HI)) dut (
    .clk_i(clk), .rst_ni(rst_n), .auto_stop_cfg_i(auto_cfg), .div_sel_i(div_sel),
    .act_sel_i(act_sel), .stop_mode_i(stop_m), .wait_mode_i(wait_m),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .count_o(count), .irq_o(irq), .rst_req_o(rreq)
  );

  // arithmetic reference built from the requirements
  int m_pre, m_cnt;
  bit m_run, m_arm, m_uf;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_cnt <= 2**CW - 1; m_run <= 0; m_arm <= 0; m_uf <= 0;
    end else begin
      automatic int ratio = div_sel ? HI : LO;
      automatic bit en = (m_run || !auto_cfg) && !stop_m && !wait_m;
      automatic bit tk = en && (m_pre == ratio - 1);
      automatic bit rf = wr_en && !wr_addr && m_arm && (wr_data == 8'hFF);
      if (en) m_pre <= tk ? 0 : m_pre + 1;
      if (wr_en && wr_addr) m_run <= 1;
      if (wr_en && !wr_addr) m_arm <= (wr_data == 8'h00);
      m_uf <= 0;
      if (rf) m_cnt <= 2**CW - 1;
      else if (tk) begin
        if (m_cnt == 0) begin m_cnt <= 2**CW - 1; m_uf <= 1; end
        else m_cnt <= m_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model(input string req);
    chk(int'(count) == m_cnt, req, int'(count), m_cnt);
    chk(irq == (m_uf && !act_sel), req, int'(irq), int'(m_uf && !act_sel));
    chk(rreq == (m_uf && act_sel), req, int'(rreq), int'(m_uf && act_sel));
  endtask

  task automatic do_reset(input bit a, input bit d, input bit s);
    @(negedge clk);
    wr_en = 0; stop_m = 0; wait_m = 0;
    auto_cfg = a; div_sel = d; act_sel = s; rst_n = 0;
    @(negedge clk);
    chk(count == FULL && !irq && !rreq, "R1", int'(count), int'(FULL));
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_model("R2");
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    cmp_model("R4");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(0, "watchdog", cyc, 150000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    int held;
    int last, gap;

    // R1 R7: free run from reset, count after k edges = FULL - k/ratio
    do_reset(0, 0, 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(int'(count) == 15 - 5 / LO, "R7", int'(count), 15 - 5 / LO);

    // R6: held until a start write
    do_reset(1, 1, 0);
    idle(20);
    chk(count == FULL, "R6", int'(count), int'(FULL));
    wr(1, 8'h5A);
    repeat (3 * HI) @(posedge clk);
    @(negedge clk);
    chk(int'(count) == 12, "R6", int'(count), 12);

    // R4 R5: key ordering
    do_reset(0, 1, 0);
    idle(5 * HI);
    wr(0, 8'hFF);
    chk(count != FULL, "R5", int'(count), 10);
    wr(0, 8'h00); wr(0, 8'h05); wr(0, 8'hFF);
    chk(count != FULL, "R5", int'(count), 10);
    wr(0, 8'h00); wr(0, 8'hFF);
    chk(count == FULL, "R4", int'(count), int'(FULL));

    // R8: stop and wait freeze
    idle(3 * HI);
    stop_m = 1;
    held = int'(count);
    idle(20);
    chk(int'(count) == held, "R8", int'(count), held);
    stop_m = 0; wait_m = 1;
    idle(20);
    chk(int'(count) == held, "R8", int'(count), held);
    wait_m = 0;
    idle(2 * HI);
    chk(int'(count) == held - 2, "R8", int'(count), held - 2);

    // R3 R9: period between pulses for both ratios and both actions
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        do_reset(0, d[0], s[0]);
        last = -1; gap = -1;
        for (int i = 0; i < 3 * HI * 16; i++) begin
          @(negedge clk);
          cmp_model("R9");
          if (irq || rreq) begin
            chk(s ? (rreq && !irq) : (irq && !rreq), "R9", int'(rreq), s);
            if (last >= 0) gap = i - last;
            last = i;
          end
        end
        chk(gap == (d ? HI : LO) * 16, "R3", gap, (d ? HI : LO) * 16);
      end
    end

    // R10: key completes on the underflow edge
    do_reset(0, 1, 0);
    while (count != '0) @(negedge clk);
    @(negedge clk); @(negedge clk);
    wr_en = 1; wr_addr = 0; wr_data = 8'h00;
    @(negedge clk);
    wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 0;
    chk(count == FULL && !irq && !rreq, "R10", int'(count), int'(FULL));
    @(negedge clk);
    chk(!irq && !rreq, "R10", int'(irq), 0);

    // sweep every configuration against the model
    for (int c = 0; c < 8; c++) begin
      do_reset(c[0], c[1], c[2]);
      for (int i = 0; i < 700; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        wr_en   = (lf[3:0] == 4'd0);
        wr_addr = (lf[6:4] == 3'd0);
        case (lf[8:7])
          2'd0:    wr_data = 8'h00;
          2'd3:    wr_data = lf[15:8];
          default: wr_data = 8'hFF;
        endcase
        stop_m = (lf[12:9] == 4'd0);
        wait_m = (lf[15:12] == 4'd1);
        @(negedge clk);
        cmp_model("R2 R8 R9 sweep");
      end
      wr_en = 0; stop_m = 0; wait_m = 0;
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule